// File: doc/BRIEF.md
# Split-Layout Memory Decoder

This block sits between a processor's memory port and its storage. Each cycle it may take one request: a 16-bit word address, a space select (program, X data or Y data), a write flag and 24 bits of write data. Small on-chip banks answer first. These are 512 program words, 256 X words and 256 Y words. Any address outside them goes to an external store. That store is built from three byte-wide devices that are always selected together, so the three devices form one 24-bit word.

Only two address bits and the space select shape the external decode. A mode pin chooses between two overlap layouts. In the 32K layout, program, X and Y at the same number reach the same external word. In the 16K layout, program and X share one 16K half and Y has the other half. In both layouts the upper half of every space mirrors the lower half. The mode pin is captured only while reset is held.

A four-state machine sequences the accesses. `ST_IDLE` waits. An accepted on-chip request moves to `ST_ONCHIP`, where the answer is ready after one edge. An accepted external request moves to `ST_EXT_WAIT`. This is the single wait state, and in it the chip selects and strobes are driven and `busy` is high. `ST_EXT_WAIT` always moves to `ST_EXT_DONE`. From `ST_IDLE`, `ST_ONCHIP` and `ST_EXT_DONE`, a new accepted request goes straight to `ST_ONCHIP` or `ST_EXT_WAIT`; with no accepted request the machine returns to `ST_IDLE`. Behavioural models of the on-chip banks and the external devices are built in, so read data comes back through the block.

Top module: `split_mem_decoder`

## Requirements
- R1: While reset is held, `rsp_done` and `busy` are 0, `int_cs` is 000, `ext_cs_n` is 111, and `ext_oe_n` and `ext_we_n` are 1.
- R2: An on-chip request is one of these: program space with an address below 0x0200, or X or Y space with an address below 0x0100. On-chip requests take priority over external memory. In the cycle after acceptance, `rsp_done` is 1, `busy` is 0, `ext_cs_n` stays 111, and `int_cs` is one-hot with bit 0 for program, bit 1 for X and bit 2 for Y. Read data is valid in that cycle.
- R3: For an external request, in the cycle after acceptance `busy` is 1 and all three `ext_cs_n` bits are 0 together. In the next cycle `busy` is 0 and `rsp_done` is 1. Strobes are active only while `busy` is 1.
- R4: During the wait cycle, a read drives `ext_oe_n` low with `ext_we_n` high, and a write drives `ext_we_n` low with `ext_oe_n` high. The two are never low together.
- R5: In 32K mode, `ext_addr[14:0]` equals address bits 14:0 for every space, so program, X and Y alias onto one store.
- R6: In 16K mode, `ext_addr[13:0]` equals address bits 13:0. `ext_addr[14]` is 1 for Y space and 0 for program and X space. Address bit 14 has no effect.
- R7: Address bit 15 never reaches the external address, so 0x8000–0xFFFF mirror 0x0000–0x7FFF.
- R8: A read returns the last value written to the same physical word, whichever space or mirror address was used to write it.
- R9: `mode_32k` is captured only while reset is held. A change while running has no effect until the next reset.
- R10: A request with space code 3 is ignored. It produces no `rsp_done`, no `int_cs` and no external strobe.
- R11: A request presented while `busy` is 1 is ignored and does not change any memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_32k | input | 1 | Layout select, 1 = 32K, 0 = 16K; captured during reset |
| req_valid | input | 1 | Request present |
| req_space | input | 2 | 0 program, 1 X data, 2 Y data, 3 reserved |
| req_addr | input | 16 | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 24 | Write data |
| rsp_done | output | 1 | Access complete; read data valid |
| rsp_rdata | output | 24 | Read data |
| busy | output | 1 | External wait cycle in progress |
| int_cs | output | 3 | On-chip bank select, one-hot |
| ext_cs_n | output | 3 | External device selects, active low |
| ext_oe_n | output | 1 | External output enable, active low |
| ext_we_n | output | 1 | External write enable, active low |
| ext_addr | output | 15 | External word address |

## Verification
The properties assume that the request inputs are known and held steady for the whole cycle in which they are sampled. They also assume that `mode_32k` only needs to be correct while reset is held. The stimulus changes inputs only on the falling edge and holds each request for exactly one rising edge. The reserved space code is sent only in the test dedicated to it. Layout changes are made either inside reset or, deliberately, outside it to show that they are ignored. External test addresses are chosen so that they differ in the address bits the behavioural store keeps.

// File: rtl/smd_pkg.sv
`timescale 1ns/1ps
package smd_pkg;
    typedef enum logic [1:0] {
        SP_PROG = 2'd0,
        SP_XDAT = 2'd1,
        SP_YDAT = 2'd2,
        SP_RSVD = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ONCHIP   = 2'd1,
        ST_EXT_WAIT = 2'd2,
        ST_EXT_DONE = 2'd3
    } state_e;

    localparam int NBANK = 3;
endpackage

// File: rtl/smd_mode_latch.sv
`timescale 1ns/1ps
module smd_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    output logic mode_q
);
    // Follows the pin only while reset is held; frozen otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= mode_i;
    end
endmodule

// File: rtl/smd_addr_decode.sv
`timescale 1ns/1ps
module smd_addr_decode
    import smd_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int EXT_AW   = 15,
    parameter int P_DEPTH  = 512,
    parameter int XY_DEPTH = 256
) (
    input  logic [1:0]        space_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              mode_32k_i,
    output logic              valid_o,
    output logic              on_chip_o,
    output logic [NBANK-1:0]  bank_o,
    output logic [EXT_AW-1:0] ext_addr_o
);
    localparam int P_AW    = $clog2(P_DEPTH);
    localparam int XY_AW   = $clog2(XY_DEPTH);
    localparam int SEL_BIT = EXT_AW - 1;

    logic p_low, xy_low;
    assign p_low  = (addr_i >> P_AW)  == '0;
    assign xy_low = (addr_i >> XY_AW) == '0;

    always_comb begin
        valid_o   = 1'b1;
        on_chip_o = 1'b0;
        bank_o    = '0;
        unique case (space_e'(space_i))
            SP_PROG: begin on_chip_o = p_low;  bank_o[0] = p_low;  end
            SP_XDAT: begin on_chip_o = xy_low; bank_o[1] = xy_low; end
            SP_YDAT: begin on_chip_o = xy_low; bank_o[2] = xy_low; end
            SP_RSVD: valid_o = 1'b0;
        endcase
    end

    // The top address bit is dropped, which gives the mirror. The fold
    // bit comes from the address in 32K mode and from the Y select in
    // 16K mode.
    always_comb begin
        ext_addr_o[SEL_BIT-1:0] = addr_i[SEL_BIT-1:0];
        ext_addr_o[SEL_BIT]     = mode_32k_i ? addr_i[SEL_BIT]
                                             : (space_e'(space_i) == SP_YDAT);
    end
endmodule

// File: rtl/smd_ctrl_fsm.sv
`timescale 1ns/1ps
module smd_ctrl_fsm
    import smd_pkg::*;
#(
    parameter int EXT_AW = 15,
    parameter int DATA_W = 24,
    parameter int LANES  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              valid_i,
    input  logic              on_chip_i,
    input  logic [NBANK-1:0]  bank_i,
    input  logic [EXT_AW-1:0] ext_addr_i,
    output logic              accept_o,
    output state_e            state_o,
    output logic              done_o,
    output logic              busy_o,
    output logic [NBANK-1:0]  int_cs_o,
    output logic [LANES-1:0]  ext_cs_n_o,
    output logic              ext_oe_n_o,
    output logic              ext_we_n_o,
    output logic [EXT_AW-1:0] ext_addr_o,
    output logic [DATA_W-1:0] ext_wdata_o
);
    state_e state_q, state_d;
    logic   go_ext;

    assign accept_o = req_valid_i && valid_i && (state_q != ST_EXT_WAIT);
    assign go_ext   = accept_o && !on_chip_i;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ONCHIP, ST_EXT_DONE:
                if (accept_o) state_d = on_chip_i ? ST_ONCHIP : ST_EXT_WAIT;
            ST_EXT_WAIT:
                state_d = ST_EXT_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_cs_o    <= '0;
            ext_cs_n_o  <= '1;
            ext_oe_n_o  <= 1'b1;
            ext_we_n_o  <= 1'b1;
            ext_addr_o  <= '0;
            ext_wdata_o <= '0;
        end else begin
            int_cs_o   <= (accept_o && on_chip_i) ? bank_i : '0;
            ext_cs_n_o <= go_ext ? '0 : '1;
            ext_oe_n_o <= !(go_ext && !req_write_i);
            ext_we_n_o <= !(go_ext && req_write_i);
            if (go_ext) begin
                ext_addr_o  <= ext_addr_i;
                ext_wdata_o <= req_wdata_i;
            end
        end
    end

    assign state_o = state_q;
    assign busy_o  = (state_q == ST_EXT_WAIT);
    assign done_o  = (state_q == ST_ONCHIP) || (state_q == ST_EXT_DONE);
endmodule

// File: rtl/smd_onchip_ram.sv
`timescale 1ns/1ps
module smd_onchip_ram
    import smd_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int P_DEPTH  = 512,
    parameter int XY_DEPTH = 256,
    localparam int P_AW    = $clog2(P_DEPTH)
) (
    input  logic              clk,
    input  logic              en_i,
    input  logic [NBANK-1:0]  bank_i,
    input  logic              we_i,
    input  logic [P_AW-1:0]   addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NBANK-1:0]  sel_q_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] bank_rd [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int DEPTH = (b == 0) ? P_DEPTH : XY_DEPTH;
        localparam int AW    = $clog2(DEPTH);
        logic [DATA_W-1:0] mem [DEPTH];
        logic [DATA_W-1:0] rd_q;
        always_ff @(posedge clk) begin
            if (en_i && bank_i[b]) begin
                if (we_i) mem[addr_i[AW-1:0]] <= wdata_i;
                else      rd_q <= mem[addr_i[AW-1:0]];
            end
        end
        assign bank_rd[b] = rd_q;
    end

    always_comb begin
        rdata_o = '0;
        for (int b = 0; b < NBANK; b++)
            if (sel_q_i[b]) rdata_o = rdata_o | bank_rd[b];
    end
endmodule

// File: rtl/smd_ext_ram.sv
`timescale 1ns/1ps
module smd_ext_ram #(
    parameter int EXT_AW      = 15,
    parameter int LANE_W      = 8,
    parameter int LANES       = 3,
    parameter int MODEL_LOW_W = 9,
    localparam int IDX_W      = MODEL_LOW_W + 1,
    localparam int DEPTH      = 2 ** IDX_W
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        cs_n_i,
    input  logic                    oe_n_i,
    input  logic                    we_n_i,
    input  logic [EXT_AW-1:0]       addr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output logic [LANES*LANE_W-1:0] rdata_o
);
    // The model keeps the fold bit and the low address bits only.
    logic [IDX_W-1:0] idx;
    logic             unused_mid;
    assign idx        = {addr_i[EXT_AW-1], addr_i[MODEL_LOW_W-1:0]};
    assign unused_mid = ^addr_i[EXT_AW-2:MODEL_LOW_W];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;
        always_ff @(posedge clk) begin
            if (!cs_n_i[l]) begin
                if (!we_n_i)      mem[idx] <= wdata_i[l*LANE_W +: LANE_W];
                else if (!oe_n_i) rd_q     <= mem[idx];
            end
        end
        assign rdata_o[l*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/split_mem_decoder.sv
`timescale 1ns/1ps
module split_mem_decoder
    import smd_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int LANE_W      = 8,
    parameter int LANES       = 3,
    parameter int EXT_AW      = 15,
    parameter int P_DEPTH     = 512,
    parameter int XY_DEPTH    = 256,
    parameter int MODEL_LOW_W = 9,
    localparam int DATA_W     = LANE_W * LANES,
    localparam int P_AW       = $clog2(P_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_32k,
    input  logic              req_valid,
    input  logic [1:0]        req_space,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              busy,
    output logic [NBANK-1:0]  int_cs,
    output logic [LANES-1:0]  ext_cs_n,
    output logic              ext_oe_n,
    output logic              ext_we_n,
    output logic [EXT_AW-1:0] ext_addr
);
    logic              mode_q;
    logic              dec_valid, dec_on_chip, accept;
    logic [NBANK-1:0]  dec_bank;
    logic [EXT_AW-1:0] dec_ext_addr;
    logic [DATA_W-1:0] ext_wdata, int_rd, ext_rd;
    state_e            state;

    smd_mode_latch u_mode (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_32k), .mode_q(mode_q)
    );

    smd_addr_decode #(
        .ADDR_W(ADDR_W), .EXT_AW(EXT_AW), .P_DEPTH(P_DEPTH), .XY_DEPTH(XY_DEPTH)
    ) u_dec (
        .space_i(req_space), .addr_i(req_addr), .mode_32k_i(mode_q),
        .valid_o(dec_valid), .on_chip_o(dec_on_chip), .bank_o(dec_bank),
        .ext_addr_o(dec_ext_addr)
    );

    smd_ctrl_fsm #(
        .EXT_AW(EXT_AW), .DATA_W(DATA_W), .LANES(LANES)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_wdata_i(req_wdata),
        .valid_i(dec_valid), .on_chip_i(dec_on_chip), .bank_i(dec_bank),
        .ext_addr_i(dec_ext_addr), .accept_o(accept), .state_o(state),
        .done_o(rsp_done), .busy_o(busy), .int_cs_o(int_cs),
        .ext_cs_n_o(ext_cs_n), .ext_oe_n_o(ext_oe_n), .ext_we_n_o(ext_we_n),
        .ext_addr_o(ext_addr), .ext_wdata_o(ext_wdata)
    );

    smd_onchip_ram #(
        .DATA_W(DATA_W), .P_DEPTH(P_DEPTH), .XY_DEPTH(XY_DEPTH)
    ) u_int_ram (
        .clk(clk), .en_i(accept && dec_on_chip), .bank_i(dec_bank),
        .we_i(req_write), .addr_i(req_addr[P_AW-1:0]), .wdata_i(req_wdata),
        .sel_q_i(int_cs), .rdata_o(int_rd)
    );

    smd_ext_ram #(
        .EXT_AW(EXT_AW), .LANE_W(LANE_W), .LANES(LANES), .MODEL_LOW_W(MODEL_LOW_W)
    ) u_ext_ram (
        .clk(clk), .cs_n_i(ext_cs_n), .oe_n_i(ext_oe_n), .we_n_i(ext_we_n),
        .addr_i(ext_addr), .wdata_i(ext_wdata), .rdata_o(ext_rd)
    );

    assign rsp_rdata = (state == ST_ONCHIP) ? int_rd : ext_rd;
endmodule

// File: rtl/split_mem_decoder_chk.sv
`timescale 1ns/1ps
module split_mem_decoder_chk #(
    parameter int LANES = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_space,
    input logic             busy,
    input logic             rsp_done,
    input logic [2:0]       int_cs,
    input logic [LANES-1:0] ext_cs_n,
    input logic             ext_oe_n,
    input logic             ext_we_n,
    input logic             mode_q
);
    assert_busy_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    assert_busy_then_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> rsp_done);
    assert_lanes_together_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_cs_n == '0) || (ext_cs_n == '1));
    assert_strobe_in_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_cs_n != '1) |-> busy);
    assert_oe_we_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_oe_n && !ext_we_n));
    assert_onchip_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(int_cs));
    assert_onchip_no_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int_cs != '0) |-> (rsp_done && !busy && ext_cs_n == '1));
    assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));
    assert_rsvd_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_space == 2'd3 && !busy) |=>
        (!rsp_done && int_cs == '0 && ext_cs_n == '1));
    assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (int_cs == '0 && !busy));
endmodule

bind split_mem_decoder split_mem_decoder_chk #(.LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_space(req_space),
    .busy(busy), .rsp_done(rsp_done), .int_cs(int_cs), .ext_cs_n(ext_cs_n),
    .ext_oe_n(ext_oe_n), .ext_we_n(ext_we_n), .mode_q(mode_q)
);

// File: tb/split_mem_decoder_bench.sv
`timescale 1ns/1ps
module split_mem_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_32k = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_space = 2'd0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [23:0] req_wdata = '0;
    logic        rsp_done, busy, ext_oe_n, ext_we_n;
    logic [23:0] rsp_rdata;
    logic [2:0]  int_cs, ext_cs_n;
    logic [14:0] ext_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    split_mem_decoder u_split_mem_decoder (
        .clk(clk), .rst_n(rst_n), .mode_32k(mode_32k), .req_valid(req_valid),
        .req_space(req_space), .req_addr(req_addr), .req_write(req_write),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .busy(busy), .int_cs(int_cs), .ext_cs_n(ext_cs_n), .ext_oe_n(ext_oe_n),
        .ext_we_n(ext_we_n), .ext_addr(ext_addr)
    );

    // {space, addr, write, wdata, external, ext_addr, read data}
    localparam int NVEC = 17;
    localparam logic [82:0] VECS [NVEC] = '{
        {2'd0, 16'h0010, 1'b1, 24'hA1B2C3, 1'b0, 15'h0000, 24'h000000}, // R2
        {2'd0, 16'h0010, 1'b0, 24'h000000, 1'b0, 15'h0000, 24'hA1B2C3}, // R2
        {2'd1, 16'h0080, 1'b1, 24'h111111, 1'b0, 15'h0000, 24'h000000}, // R2
        {2'd2, 16'h0080, 1'b1, 24'h222222, 1'b0, 15'h0000, 24'h000000}, // R2
        {2'd1, 16'h0080, 1'b0, 24'h000000, 1'b0, 15'h0000, 24'h111111}, // R2
        {2'd2, 16'h0080, 1'b0, 24'h000000, 1'b0, 15'h0000, 24'h222222}, // R2
        {2'd0, 16'h0300, 1'b1, 24'h5A5A5A, 1'b1, 15'h0300, 24'h000000}, // R5
        {2'd1, 16'h0300, 1'b0, 24'h000000, 1'b1, 15'h0300, 24'h5A5A5A}, // R5 R8
        {2'd2, 16'h0300, 1'b0, 24'h000000, 1'b1, 15'h0300, 24'h5A5A5A}, // R5 R8
        {2'd2, 16'h4300, 1'b1, 24'h0F0F0F, 1'b1, 15'h4300, 24'h000000}, // R5
        {2'd0, 16'hC300, 1'b0, 24'h000000, 1'b1, 15'h4300, 24'h0F0F0F}, // R7
        {2'd1, 16'h8300, 1'b0, 24'h000000, 1'b1, 15'h0300, 24'h5A5A5A}, // R7
        {2'd1, 16'h01C0, 1'b1, 24'hABCDEF, 1'b1, 15'h01C0, 24'h000000}, // R2 X above bank
        {2'd2, 16'h01C0, 1'b0, 24'h000000, 1'b1, 15'h01C0, 24'hABCDEF}, // R5 R8
        {2'd0, 16'h01C0, 1'b1, 24'h777000, 1'b0, 15'h0000, 24'h000000}, // R2 priority
        {2'd0, 16'h01C0, 1'b0, 24'h000000, 1'b0, 15'h0000, 24'h777000}, // R2 priority
        {2'd1, 16'h01C0, 1'b0, 24'h000000, 1'b1, 15'h01C0, 24'hABCDEF}  // R2 R8
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Starts and ends on a falling edge.
    task automatic access(input logic [1:0] sp, input logic [15:0] a, input logic w,
                          input logic [23:0] wd, input logic ext,
                          input logic [14:0] ea, input logic [23:0] rd);
        req_valid = 1'b1; req_space = sp; req_addr = a; req_write = w; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (ext) begin
            check("R3 busy in wait", 32'(busy), 32'd1);
            check("R3 all lanes selected", 32'(ext_cs_n), 32'd0);
            check("R3 no done in wait", 32'(rsp_done), 32'd0);
            check("R5/R6/R7 ext_addr", 32'(ext_addr), 32'(ea));
            check("R4 oe_n", 32'(ext_oe_n), 32'(w));
            check("R4 we_n", 32'(ext_we_n), 32'(!w));
            @(negedge clk);
            check("R3 done after wait", 32'(rsp_done), 32'd1);
            check("R3 busy released", 32'(busy), 32'd0);
            if (!w) check("R8 ext read data", 32'(rsp_rdata), 32'(rd));
        end else begin
            check("R2 done no wait", 32'(rsp_done), 32'd1);
            check("R2 no busy", 32'(busy), 32'd0);
            check("R2 int_cs", 32'(int_cs), 32'(3'b001 << sp));
            check("R2 ext idle", 32'(ext_cs_n), 32'h7);
            if (!w) check("R2 on-chip read data", 32'(rsp_rdata), 32'(rd));
        end
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0; mode_32k = mode; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 done in reset", 32'(rsp_done), 32'd0);
        check("R1 busy in reset", 32'(busy), 32'd0);
        check("R1 int_cs in reset", 32'(int_cs), 32'd0);
        check("R1 ext_cs_n in reset", 32'(ext_cs_n), 32'h7);
        check("R1 strobes in reset", 32'({ext_oe_n, ext_we_n}), 32'h3);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // 32K layout, table walk
        do_reset(1'b1);
        for (int i = 0; i < NVEC; i++) begin
            access(VECS[i][82:81], VECS[i][80:65], VECS[i][64], VECS[i][63:40],
                   VECS[i][39], VECS[i][38:24], VECS[i][23:0]);
        end

        // R10: reserved space code
        req_valid = 1'b1; req_space = 2'd3; req_addr = 16'h0010; req_write = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 no done", 32'(rsp_done), 32'd0);
        check("R10 no int_cs", 32'(int_cs), 32'd0);
        check("R10 no ext strobe", 32'(ext_cs_n), 32'h7);
        access(2'd0, 16'h0010, 1'b0, 24'h0, 1'b0, 15'h0, 24'hA1B2C3); // R10 data intact

        // R11: request during wait is ignored
        access(2'd0, 16'h0020, 1'b1, 24'h777777, 1'b0, 15'h0, 24'h0);
        req_valid = 1'b1; req_space = 2'd1; req_addr = 16'h0300; req_write = 1'b0;
        @(negedge clk);
        check("R11 busy", 32'(busy), 32'd1);
        req_space = 2'd0; req_addr = 16'h0020; req_write = 1'b1; req_wdata = 24'hDEAD00;
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 done after wait", 32'(rsp_done), 32'd1);
        check("R11 no on-chip select", 32'(int_cs), 32'd0);
        check("R11 ext data", 32'(rsp_rdata), 32'h5A5A5A);
        @(negedge clk);
        access(2'd0, 16'h0020, 1'b0, 24'h0, 1'b0, 15'h0, 24'h777777); // R11 not written

        // 16K layout
        do_reset(1'b0);
        access(2'd0, 16'h0300, 1'b1, 24'h123456, 1'b1, 15'h0300, 24'h0); // R6
        access(2'd2, 16'h0300, 1'b1, 24'h654321, 1'b1, 15'h4300, 24'h0); // R6 Y half
        access(2'd1, 16'h0300, 1'b0, 24'h0, 1'b1, 15'h0300, 24'h123456); // R6 P/X shared
        access(2'd2, 16'h4300, 1'b0, 24'h0, 1'b1, 15'h4300, 24'h654321); // R6 bit14 ignored
        access(2'd1, 16'h4300, 1'b0, 24'h0, 1'b1, 15'h0300, 24'h123456); // R6 mirror
        access(2'd0, 16'h8300, 1'b0, 24'h0, 1'b1, 15'h0300, 24'h123456); // R7

        // R9: mode change while running has no effect
        mode_32k = 1'b1;
        @(negedge clk);
        access(2'd2, 16'h0300, 1'b0, 24'h0, 1'b1, 15'h4300, 24'h654321); // R9
        do_reset(1'b1);
        access(2'd2, 16'h0300, 1'b0, 24'h0, 1'b1, 15'h0300, 24'h123456); // R9 after reset

        finish_run();
    end
endmodule